// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

A line buffer of 5120 words by 8 bits with a write port and a read port on two unrelated clocks. Each port keeps its own address counter, has an active-low enable and an active-low reset, and the reset of one port touches only that port's counter. There are no full or empty flags and no comparison between the two counters. The delay from input to output is set by the caller, either by the relative timing of the two resets or by holding the read enable inactive for a number of cycles.

Each port is a small state machine. The write side has the states `WS_UNINIT` (power-up, before the first write reset), `WS_HOLD` (last edge had the enable high) and `WS_STORE` (last edge stored a word). A write reset leaves `WS_UNINIT` for `WS_STORE` or `WS_HOLD` depending on the enable. After that, the enable picks between the two run states on every edge. The read side has the matching states `RS_UNINIT`, `RS_IDLE` and `RS_READ`, and the transitions follow the same rule on the read reset and read enable. The output enable is driven from the read state: it is all ones in `RS_READ` and all zeros otherwise, which stands for a high-impedance bus.

A typical use is a one-line delay for image rows. Both resets are pulsed together, both enables are held active, and every word comes back out exactly one line later.

Top module: `line_delay_mem`

## Requirements
- R1: Both address counters run from 0 to 5119 and wrap from 5119 back to 0.
- R2: On a rising write-clock edge with `wr_en_n` low, `wr_data` is stored at the write address and the write address advances by one.
- R3: On a rising write-clock edge with `wr_en_n` high, nothing is stored and the write address keeps its value.
- R4: On an edge with `wr_rst_n` low and `wr_en_n` low, the word is stored at address 0. The words of the next enabled edges go to addresses 1, 2 and onward.
- R5: On a rising read-clock edge with `rd_en_n` low, `rd_data` takes the word at the read address, `rd_oe` becomes 8'hFF, and the read address advances by one.
- R6: On a rising read-clock edge with `rd_en_n` high, the read address keeps its value, `rd_oe` becomes 8'h00 and `rd_data` becomes 8'h00.
- R7: Every edge with `rd_rst_n` low and `rd_en_n` low presents the word at address 0. The first enabled edge after the reset is released presents address 1, the next one address 2.
- R8: A location that has not been written since power-up reads as 8'h00.
- R9: If both resets are low on the same edge and both enables stay low, with the clocks equal, `rd_data` on edge t equals the `wr_data` of edge t-5120.
- R10: With equal clocks and both enables low, a read reset applied n edges after the write reset gives `rd_data` on edge t equal to the `wr_data` of edge t-n.
- R11: With equal clocks, a common reset with `rd_en_n` held high on that edge and the next n-1 edges, then low, gives `rd_data` on edge t >= n equal to the `wr_data` of edge t-n.
- R12: Before the first read reset, the read port ignores `rd_en_n` and `rd_oe` stays 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write address reset, active low, synchronous to `wr_clk` |
| wr_data | input | 8 | Word to store |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_rst_n | input | 1 | Read address reset, active low, synchronous to `rd_clk` |
| rd_data | output | 8 | Word read out; zero while the output is disabled |
| rd_oe | output | 8 | Per-bit output enable; zero stands for high impedance |

## Verification
A block of words is written on one clock and read back on an unrelated, slower clock after the writes are done. This shows that the address of each word matches on both sides, that the reset word lands at address 0, and that never-written locations read zero. The same pattern is repeated with enable gaps on both sides and a held read reset. Here the write gaps show whether skipped data was stored or the address moved, and the read gaps show whether the counter held and the bus floated. With the two clocks tied together, three delay set-ups are run: common reset for a full line, staggered resets, and a held-off read enable. These show whether the counters wrap at exactly 5120 and whether reads on the same edge return the old word before it is overwritten.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    // Write-port control states
    typedef enum logic [1:0] {
        WS_UNINIT = 2'd0,   // power-up, waiting for first write reset
        WS_HOLD   = 2'd1,   // last edge had enable inactive
        WS_STORE  = 2'd2    // last edge stored a word
    } wr_state_e;

    // Read-port control states
    typedef enum logic [1:0] {
        RS_UNINIT = 2'd0,   // power-up, waiting for first read reset
        RS_IDLE   = 2'd1,   // output floating, counter held
        RS_READ   = 2'd2    // output driving the fetched word
    } rd_state_e;

endpackage

// File: rtl/lb_wr_ctrl.sv
module lb_wr_ctrl
    import lbuf_pkg::*;
#(
    parameter int DEPTH = 5120,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic          rst_n,
    output logic          we,
    output logic [AW-1:0] waddr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    wr_state_e     state_q = WS_UNINIT;
    wr_state_e     state_d;
    logic [AW-1:0] addr_q  = '0;
    logic [AW-1:0] addr_d;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        addr_q  <= addr_d;
    end

    // Next state and address
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            WS_UNINIT: begin
                if (!rst_n) begin
                    state_d = en_n ? WS_HOLD : WS_STORE;
                    addr_d  = en_n ? '0 : AW'(1);
                end
            end
            WS_HOLD, WS_STORE: begin
                state_d = en_n ? WS_HOLD : WS_STORE;
                if (!rst_n)
                    addr_d = en_n ? '0 : AW'(1);
                else if (!en_n)
                    addr_d = (addr_q == LAST) ? '0 : addr_q + AW'(1);
            end
            default: state_d = WS_UNINIT;
        endcase
    end

    // Outputs to the array
    always_comb begin
        we    = !en_n && (!rst_n || state_q != WS_UNINIT);
        waddr = !rst_n ? '0 : addr_q;
    end

    a_r3_hold_addr: assert property (@(posedge clk) disable iff (state_q == WS_UNINIT)
        (rst_n && en_n) |=> $stable(addr_q));
    a_r2_advance: assert property (@(posedge clk) disable iff (state_q == WS_UNINIT)
        (rst_n && !en_n) |=> (addr_q != $past(addr_q)));
    a_r4_restart: assert property (@(posedge clk)
        (!rst_n && !en_n) |=> (addr_q == AW'(1)));
    a_r1_range: assert property (@(posedge clk) addr_q <= LAST);

endmodule

// File: rtl/lb_rd_ctrl.sv
module lb_rd_ctrl
    import lbuf_pkg::*;
#(
    parameter int DEPTH = 5120,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic          rst_n,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] oe
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rd_state_e     state_q = RS_UNINIT;
    rd_state_e     state_d;
    logic [AW-1:0] addr_q  = '0;
    logic [AW-1:0] addr_d;

    // State register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        addr_q  <= addr_d;
    end

    // Next state and address
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RS_UNINIT: begin
                if (!rst_n) begin
                    state_d = en_n ? RS_IDLE : RS_READ;
                    addr_d  = en_n ? '0 : AW'(1);
                end
            end
            RS_IDLE, RS_READ: begin
                state_d = en_n ? RS_IDLE : RS_READ;
                if (!rst_n)
                    addr_d = en_n ? '0 : AW'(1);
                else if (!en_n)
                    addr_d = (addr_q == LAST) ? '0 : addr_q + AW'(1);
            end
            default: state_d = RS_UNINIT;
        endcase
    end

    // Outputs: fetch strobe, fetch address, bus enable
    always_comb begin
        re    = !en_n && (!rst_n || state_q != RS_UNINIT);
        raddr = !rst_n ? '0 : addr_q;
        oe    = (state_q == RS_READ) ? '1 : '0;
    end

    a_r6_float: assert property (@(posedge clk) disable iff (state_q == RS_UNINIT)
        en_n |=> (oe == '0));
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (state_q == RS_UNINIT)
        (rst_n && en_n) |=> $stable(addr_q));
    a_r5_drive: assert property (@(posedge clk) disable iff (state_q == RS_UNINIT)
        !en_n |=> (oe == '1));
    a_r7_restart: assert property (@(posedge clk)
        (!rst_n && !en_n) |=> (addr_q == AW'(1) && oe == '1));
    a_r12_ignore: assert property (@(posedge clk)
        (state_q == RS_UNINIT && rst_n) |=> (oe == '0));

endmodule

// File: rtl/lb_ram.sv
module lb_ram #(
    parameter int DEPTH = 5120,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH] = '{default: '0};
    logic [DW-1:0] rdata_q = '0;

    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re)
            rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
    import lbuf_pkg::*;
#(
    parameter int DEPTH = 5120,
    parameter int DW    = 8
) (
    input  logic          wr_clk,
    input  logic          wr_en_n,
    input  logic          wr_rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_clk,
    input  logic          rd_en_n,
    input  logic          rd_rst_n,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_oe
);

    localparam int AW = $clog2(DEPTH);

    logic          w_we;
    logic [AW-1:0] w_addr;
    logic          r_re;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_word;

    lb_wr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk   (wr_clk),
        .en_n  (wr_en_n),
        .rst_n (wr_rst_n),
        .we    (w_we),
        .waddr (w_addr)
    );

    lb_rd_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rd (
        .clk   (rd_clk),
        .en_n  (rd_en_n),
        .rst_n (rd_rst_n),
        .re    (r_re),
        .raddr (r_addr),
        .oe    (rd_oe)
    );

    lb_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
        .wclk  (wr_clk),
        .we    (w_we),
        .waddr (w_addr),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (r_re),
        .raddr (r_addr),
        .rdata (r_word)
    );

    // Disabled bits read as zero, standing in for a floating bus
    assign rd_data = r_word & rd_oe;

    a_r6_zero_when_off: assert property (@(posedge rd_clk)
        (rd_oe == '0) |-> (rd_data == '0));

endmodule

// File: tb/tb_line_delay_mem.sv
module tb_line_delay_mem;

    localparam int L = 5120;

    logic       wr_clk = 1'b0;
    logic       rd_free = 1'b0;
    logic       sync_clk = 1'b0;
    logic       rd_clk;
    logic       wr_en_n = 1'b1, wr_rst_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en_n = 1'b1, rd_rst_n = 1'b1;
    logic [7:0] rd_data, rd_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic mon_on = 1'b0;
    string tag = "";
    logic [7:0] exp_q[$];

    always #4 wr_clk = ~wr_clk;     // 125 MHz
    always #7 rd_free = ~rd_free;   // unrelated read clock
    assign rd_clk = sync_clk ? wr_clk : rd_free;

    line_delay_mem dut (
        .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_rst_n(rd_rst_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected words as the read port produces them
    always @(posedge rd_clk) begin
        logic en_s, on_s;
        en_s = rd_en_n;
        on_s = mon_on;
        #1;
        if (on_s) begin
            if (!en_s) begin
                check8({tag, " oe"}, rd_oe, 8'hFF);
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL %s: got %h expected <none> (queue empty)", tag, rd_data);
                end else begin
                    check8(tag, rd_data, exp_q.pop_front());
                end
            end else begin
                check8({tag, " R6 float"}, rd_oe, 8'h00);
                check8({tag, " R6 data"}, rd_data, 8'h00);
            end
        end
    end

    task automatic w_step(logic r, logic e, logic [7:0] d);
        wr_rst_n = r; wr_en_n = e; wr_data = d;
        @(posedge wr_clk); #1;
    endtask

    task automatic r_step(logic r, logic e);
        rd_rst_n = r; rd_en_n = e;
        @(posedge rd_clk); #1;
    endtask

    task automatic s_step(logic wr, logic we, logic [7:0] wd, logic rr, logic re, logic mon);
        wr_rst_n = wr; wr_en_n = we; wr_data = wd;
        rd_rst_n = rr; rd_en_n = re; mon_on = mon;
        @(posedge wr_clk); #1;
    endtask

    function automatic logic [7:0] pat(int c, int salt);
        return 8'((c * 13) + (c >>> 8) + salt);
    endfunction

    task automatic drain_check(string req);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: got %0d words left expected 0", req, exp_q.size());
        end
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        // P0 (R12): enable before any read reset is ignored
        #1;
        check8("R12 oe at power-up", rd_oe, 8'h00);
        r_step(1'b1, 1'b0);
        r_step(1'b1, 1'b0);
        check8("R12 oe without reset", rd_oe, 8'h00);
        check8("R12 data without reset", rd_data, 8'h00);
        r_step(1'b1, 1'b1);

        // P1 (R2 R4 R5 R8): ten words from address 0, two unwritten reads
        w_step(1'b0, 1'b0, 8'h10);
        exp_q.push_back(8'h10);
        for (int k = 1; k < 10; k++) begin
            w_step(1'b1, 1'b0, 8'(8'h10 + k * 3));
            exp_q.push_back(8'(8'h10 + k * 3));
        end
        w_step(1'b1, 1'b1, 8'h77);
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h00);
        tag = "R2 R4 R5 R8 P1";
        mon_on = 1'b1;
        r_step(1'b0, 1'b0);
        for (int k = 1; k < 12; k++) r_step(1'b1, 1'b0);
        r_step(1'b1, 1'b1);
        mon_on = 1'b0;
        drain_check("R5 P1 count");

        // P2 (R3 R6 R7): write gaps, held read reset, read pause
        w_step(1'b0, 1'b0, 8'hC0);
        exp_q.push_back(8'hC0);
        for (int k = 1; k < 20; k++) begin
            if (k == 6 || k == 13) begin
                w_step(1'b1, 1'b1, 8'hEE);
                w_step(1'b1, 1'b1, 8'hE1);
            end
            w_step(1'b1, 1'b0, 8'(8'hC0 ^ (k * 5)));
            exp_q.push_back(8'(8'hC0 ^ (k * 5)));
        end
        w_step(1'b1, 1'b1, 8'h00);
        exp_q.push_front(8'hC0);   // reset held two edges: word 0 twice
        tag = "R3 R7 P2";
        mon_on = 1'b1;
        r_step(1'b0, 1'b0);
        r_step(1'b0, 1'b0);
        for (int k = 1; k < 20; k++) begin
            if (k == 9) begin
                r_step(1'b1, 1'b1);
                r_step(1'b1, 1'b1);
                r_step(1'b1, 1'b1);
            end
            r_step(1'b1, 1'b0);
        end
        r_step(1'b1, 1'b1);
        mon_on = 1'b0;
        drain_check("R3 R7 P2 count");

        // Tie the read clock to the write clock
        @(negedge wr_clk);
        sync_clk = 1'b1;
        @(posedge wr_clk); #1;

        // P3 (R1 R9): common reset, one full line of delay
        tag = "R1 R9 line";
        for (int c = 0; c < L + 20; c++) begin
            exp_q.push_back(pat(c, 1));
            s_step(c != 0, 1'b0, pat(c, 1), c != 0, 1'b0, c >= L);
        end
        s_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        n_tests++;
        if (exp_q.size() != L) begin
            n_fail++;
            $display("FAIL R9: got %0d unread expected %0d", exp_q.size(), L);
        end
        exp_q.delete();

        // P4 (R10): read reset seven edges after write reset
        tag = "R10 staggered";
        for (int c = 0; c < 40; c++) begin
            exp_q.push_back(pat(c, 91));
            s_step(c != 0, 1'b0, pat(c, 91), c != 7, 1'b0, c >= 7);
        end
        s_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        exp_q.delete();

        // P5 (R11): common reset, read enable held off for seven edges
        tag = "R11 held";
        for (int c = 0; c < 40; c++) begin
            exp_q.push_back(pat(c, 47));
            s_step(c != 0, 1'b0, pat(c, 47), c != 0, c < 7, 1'b1);
        end
        s_step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        exp_q.delete();

        finish_up();
    end

endmodule